// File: doc/BRIEF.md
# Adaptive CORDIC Angle Selector

This block turns a signed angle in degrees into a short list of micro-rotation commands for a downstream CORDIC rotation datapath. It first folds the angle into the range from 0° to 45° using eighth-of-circle symmetry, and keeps a 4-bit fold code so that the datapath can later rebuild sine and cosine. It then picks one arctangent table entry per clock cycle. It does not walk the table in order: it takes whichever entry brings the residual angle closest to zero. It stops as soon as the residual is within a fixed tolerance.

The angle is 24 bits wide with 15 fraction bits, so one LSB is 2^-15 degree. The table holds atan(2^-i) in degrees for i = 0..15, rounded to the nearest LSB. The selection boundary for entry i is the midpoint between entry i and entry i+1. For the final entry the boundary is half its own value. The tolerance TOL is also half the final entry, which is 28 LSB.

The angle arrives on a valid/ready input. Commands leave on a valid/ready stream that can feed a FIFO, one command per cycle while the receiver accepts. Only one angle is in flight at a time.

Top module: `cordic_angle_sel`

## Requirements
- R1: Every command carries fold code {neg, oct}. The top bit neg is set when the input angle is negative. The low three bits oct are floor(a/45°), where a is the angle taken modulo 360° into [0°, 360°).
- R2: The start residual is a - 45°·oct, subtracted from 45° when oct is odd. After the last command, this residual minus the signed sum of the selected table angles has magnitude at most TOL.
- R3: The selected table index out_idx is the lowest i whose boundary is strictly below the residual magnitude |z|.
- R4: out_dir is 1 when the residual is negative and 0 otherwise. The residual then becomes z - θ when z ≥ 0 and z + θ when z < 0.
- R5: out_last is 2'b01 when |z| lies within TOL of the selected table angle, and 2'b00 otherwise. A stream ends with its 2'b01 command, and the code 2'b11 never appears.
- R6: If the folded angle is at most TOL, exactly one command is issued, with out_last = 2'b10, out_idx = 0 and out_dir = 0.
- R7: in_ready is low while an angle is being processed and while a command is waiting on a stalled output. The cycle after an angle is accepted, in_ready is low.
- R8: While out_valid is high and out_ready is low, the command stays valid and all of its fields stay unchanged.
- R9: During reset and in the cycle after it, out_valid is 0. When reset ends, in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input angle is valid |
| in_ready | output | 1 | Block can take an angle |
| in_angle | input | ANG_W (24) | Signed angle, degrees, 15 fraction bits |
| out_valid | output | 1 | Command is valid |
| out_ready | input | 1 | Receiver takes the command |
| out_code | output | 4 | Fold code {neg, oct} |
| out_last | output | 2 | 00 more follow, 01 final rotation, 10 no rotation |
| out_dir | output | 1 | 1 rotates by the negative table angle |
| out_idx | output | IDX_W (4) | Table index |

## Verification
A wrong residual register or a wrong fold shows up at the ports within a few cycles. The signed sum of the issued table angles then misses the folded target by more than TOL at the end of the stream, or the index or direction sequence differs from one computed independently from a freshly built arctangent table. A comparator boundary that is off by one shows up as a different index in the very command that hits it. A wrong termination rule shows up as a stream that is too long or too short. Broken handshake state shows up in the cycle after acceptance or during a stall, as in_ready going high too early or command fields changing.

// File: rtl/cordic_sel_pkg.sv
package cordic_sel_pkg;

  localparam int FRAC_W  = 15;
  localparam int TAB_MAX = 16;

  typedef enum logic [1:0] {
    LAST_MORE = 2'b00,
    LAST_ROT  = 2'b01,
    LAST_NONE = 2'b10
  } last_e;

  // atan(2^-i) in degrees, scaled by 2^FRAC_W and rounded
  function automatic int theta_q(input int i);
    case (i)
      0:  theta_q = 1474560;
      1:  theta_q = 870484;
      2:  theta_q = 459940;
      3:  theta_q = 233473;
      4:  theta_q = 117189;
      5:  theta_q = 58652;
      6:  theta_q = 29333;
      7:  theta_q = 14667;
      8:  theta_q = 7334;
      9:  theta_q = 3667;
      10: theta_q = 1833;
      11: theta_q = 917;
      12: theta_q = 458;
      13: theta_q = 229;
      14: theta_q = 115;
      default: theta_q = 57;
    endcase
  endfunction

  // selection boundary of entry i for an n-entry table
  function automatic int bound_q(input int i, input int n);
    if (i < n - 1) bound_q = (theta_q(i) + theta_q(i + 1)) / 2;
    else           bound_q = theta_q(i) / 2;
  endfunction

  function automatic int tol_q(input int n);
    tol_q = theta_q(n - 1) / 2;
  endfunction

endpackage

// File: rtl/angle_fold.sv
module angle_fold
  import cordic_sel_pkg::*;
#(
  parameter int ANG_W = 24,
  localparam int AW   = ANG_W + 1
) (
  input  logic [ANG_W-1:0] angle,
  output logic [AW-1:0]    folded,
  output logic [3:0]       code
);

  localparam logic [AW-1:0] FULL   = AW'(360 << FRAC_W);
  localparam logic [AW-1:0] EIGHTH = AW'(45 << FRAC_W);

  logic          neg;
  logic [AW-1:0] ext;
  logic [AW-1:0] a360;
  logic [6:0]    ge;
  logic [2:0]    oct;
  logic [AW-1:0] rem;

  assign neg  = angle[ANG_W-1];
  assign ext  = {angle[ANG_W-1], angle};
  assign a360 = ext + (neg ? FULL : '0);

  for (genvar k = 1; k < 8; k++) begin : g_edge
    localparam logic [AW-1:0] EDGE = AW'(k * (45 << FRAC_W));
    assign ge[k-1] = (a360 >= EDGE);
  end

  assign oct    = 3'($countones(ge));
  assign rem    = a360 - AW'(oct) * EIGHTH;
  assign folded = oct[0] ? (EIGHTH - rem) : rem;
  assign code   = {neg, oct};

endmodule

// File: rtl/rot_pick.sv
module rot_pick
  import cordic_sel_pkg::*;
#(
  parameter int ZW    = 25,
  parameter int N_ROT = 16,
  localparam int IDX_W = $clog2(N_ROT),
  localparam int TOL   = tol_q(N_ROT)
) (
  input  logic [ZW-1:0]    z,
  output logic [IDX_W-1:0] idx,
  output logic             dir,
  output logic [1:0]       last,
  output logic [ZW-1:0]    z_next
);

  logic [ZW-1:0]    mag;
  logic [N_ROT-1:0] gt;
  logic [ZW-1:0]    th_tab [N_ROT];
  logic [ZW-1:0]    lo_tab [N_ROT];
  logic [ZW-1:0]    hi_tab [N_ROT];
  logic [ZW-1:0]    th_sel;
  logic             empty;
  logic             fin;

  assign mag = z[ZW-1] ? (~z + 1'b1) : z;

  for (genvar g = 0; g < N_ROT; g++) begin : g_bank
    localparam logic [ZW-1:0] BND = ZW'(bound_q(g, N_ROT));
    assign gt[g]     = (mag > BND);
    assign th_tab[g] = ZW'(theta_q(g));
    assign lo_tab[g] = ZW'(theta_q(g) - TOL);
    assign hi_tab[g] = ZW'(theta_q(g) + TOL);
  end

  always_comb begin
    idx = '0;
    for (int i = N_ROT - 1; i >= 0; i--) begin
      if (gt[i]) idx = IDX_W'(i);
    end
  end

  assign th_sel = th_tab[idx];
  assign empty  = (mag <= ZW'(TOL));
  assign fin    = (mag >= lo_tab[idx]) && (mag <= hi_tab[idx]);
  assign dir    = empty ? 1'b0 : z[ZW-1];

  always_comb begin
    if (empty)    last = LAST_NONE;
    else if (fin) last = LAST_ROT;
    else          last = LAST_MORE;
  end

  assign z_next = empty ? z : (z[ZW-1] ? z + th_sel : z - th_sel);

endmodule

// File: rtl/cordic_angle_sel.sv
module cordic_angle_sel
  import cordic_sel_pkg::*;
#(
  parameter int ANG_W = 24,
  parameter int N_ROT = 16,
  localparam int IDX_W = $clog2(N_ROT),
  localparam int ZW    = ANG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ANG_W-1:0] in_angle,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       out_code,
  output logic [1:0]       out_last,
  output logic             out_dir,
  output logic [IDX_W-1:0] out_idx
);

  logic             busy;
  logic [ZW-1:0]    z_q;
  logic [3:0]       code_q;
  logic [ZW-1:0]    fold_z;
  logic [3:0]       fold_code;
  logic [IDX_W-1:0] p_idx;
  logic             p_dir;
  logic [1:0]       p_last;
  logic [ZW-1:0]    p_znext;
  logic             accept;
  logic             adv;

  angle_fold #(.ANG_W(ANG_W)) u_fold (
    .angle  (in_angle),
    .folded (fold_z),
    .code   (fold_code)
  );

  rot_pick #(.ZW(ZW), .N_ROT(N_ROT)) u_pick (
    .z      (z_q),
    .idx    (p_idx),
    .dir    (p_dir),
    .last   (p_last),
    .z_next (p_znext)
  );

  assign in_ready = !busy && !(out_valid && !out_ready);
  assign accept   = in_valid && in_ready;
  assign adv      = busy && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      z_q       <= '0;
      code_q    <= '0;
      out_valid <= 1'b0;
      out_code  <= '0;
      out_last  <= '0;
      out_dir   <= 1'b0;
      out_idx   <= '0;
    end else begin
      if (accept) begin
        busy   <= 1'b1;
        z_q    <= fold_z;
        code_q <= fold_code;
      end
      if (adv) begin
        out_valid <= 1'b1;
        out_code  <= code_q;
        out_last  <= p_last;
        out_dir   <= p_dir;
        out_idx   <= p_idx;
        z_q       <= p_znext;
        if (p_last != LAST_MORE) busy <= 1'b0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cordic_angle_sel_chk.sv
module cordic_angle_sel_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [3:0]       out_code,
  input logic [1:0]       out_last,
  input logic             out_dir,
  input logic [IDX_W-1:0] out_idx
);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) &&
      $stable(out_last) && $stable(out_dir) && $stable(out_idx)));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_stall_blocks_input_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_empty_fields_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last == 2'b10) |-> (out_idx == '0 && !out_dir));

  assert_no_bad_last_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_last != 2'b11));

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

endmodule

bind cordic_angle_sel cordic_angle_sel_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code  (out_code),
  .out_last  (out_last),
  .out_dir   (out_dir),
  .out_idx   (out_idx)
);

// File: tb/cordic_angle_sel_bench.sv
`timescale 1ns/1ps
module cordic_angle_sel_bench;

  localparam int NV = 16;
  localparam int Q  = 32768;
  localparam int V_ANG [NV] = '{983040, 0, -983040, 3293184, 6553600, -6553600,
                                1474560, 2949120, 4423680, 8355840, -3276800,
                                1, -1, 737280, 8388607, -8388608};
  localparam int V_CODE [NV] = '{0, 0, 15, 2, 4, 11, 1, 2, 3, 5, 13, 0, 15, 0, 5, 10};
  localparam bit V_STALL [NV] = '{1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_angle = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_code;
  logic [1:0]  out_last;
  logic        out_dir;
  logic [3:0]  out_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int th [16];
  int bd [16];
  int tol;
  int e_idx [32];
  int e_dir [32];
  int e_last [32];
  int e_n;
  int e_fold;

  cordic_angle_sel u_cordic_angle_sel (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_angle(in_angle), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_last(out_last), .out_dir(out_dir), .out_idx(out_idx)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog R7 actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build_tables();
    real pi;
    pi = 4.0 * $atan(1.0);
    for (int i = 0; i < 16; i++)
      th[i] = $rtoi($atan(2.0 ** (-i)) * 180.0 / pi * Q + 0.5);
    for (int i = 0; i < 15; i++) bd[i] = (th[i] + th[i+1]) / 2;
    bd[15] = th[15] / 2;
    tol = th[15] / 2;
  endtask

  task automatic model(input int ang);
    int a, oct, rem, z, m, j;
    a = (ang < 0) ? ang + 360 * Q : ang;
    oct = a / (45 * Q);
    rem = a - oct * 45 * Q;
    e_fold = (oct % 2 == 1) ? 45 * Q - rem : rem;
    z = e_fold;
    e_n = 0;
    for (int s = 0; s < 32; s++) begin
      m = (z < 0) ? -z : z;
      if (m <= tol) begin
        if (e_n == 0) begin
          e_idx[0] = 0; e_dir[0] = 0; e_last[0] = 2; e_n = 1;
        end
        break;
      end
      j = 0;
      for (int i = 15; i >= 0; i--) if (bd[i] < m) j = i;
      e_idx[e_n] = j;
      e_dir[e_n] = (z < 0) ? 1 : 0;
      e_last[e_n] = (m >= th[j] - tol && m <= th[j] + tol) ? 1 : 0;
      z = (z < 0) ? z + th[j] : z - th[j];
      e_n = e_n + 1;
      if (e_last[e_n-1] == 1) break;
    end
  endtask

  task automatic run_one(input int ang, input int exp_code, input bit stall);
    int k, res, h_idx, h_last, h_dir, h_code;
    model(ang);
    @(negedge clk);
    in_angle = ang[23:0];
    in_valid = 1'b1;
    if (stall) out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R7 ready after accept", int'(in_ready), 0);
    if (stall) begin
      @(negedge clk);
      h_idx = out_idx; h_last = out_last; h_dir = out_dir; h_code = out_code;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
      check(out_idx == h_idx && out_last == h_last && out_dir == h_dir &&
            out_code == h_code, "R8 fields stable", int'(out_idx), h_idx);
      check(in_ready == 1'b0, "R7 ready in stall", int'(in_ready), 0);
      out_ready = 1'b1;
    end
    k = 0;
    res = e_fold;
    for (int w = 0; w < 40; w++) begin
      if (out_valid) begin
        if (k < e_n) begin
          check(out_code == exp_code, "R1 code", int'(out_code), exp_code);
          check(out_idx == e_idx[k], "R3 index", int'(out_idx), e_idx[k]);
          check(out_dir == e_dir[k], "R4 direction", int'(out_dir), e_dir[k]);
          if (e_last[k] == 2) check(out_last == 2, "R6 empty code", int'(out_last), 2);
          else check(out_last == e_last[k], "R5 last code", int'(out_last), e_last[k]);
        end
        if (out_last != 2) res = out_dir ? res + th[out_idx] : res - th[out_idx];
        k = k + 1;
        if (out_last != 0) break;
      end
      @(negedge clk);
    end
    check(k == e_n, "R5 command count", k, e_n);
    check(res <= tol && res >= -tol, "R2 residual", res, 0);
  endtask

  initial begin
    build_tables();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);

    for (int v = 0; v < NV; v++) run_one(V_ANG[v], V_CODE[v], V_STALL[v]);

    // reset in the middle of a stream
    @(negedge clk);
    in_angle = 24'(983040);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 valid after mid reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 ready after mid reset", int'(in_ready), 1);

    // an angle right after reset still runs correctly
    run_one(-983040, 15, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule